// File: doc/BRIEF.md
# Configuration Image Fallback Selector

This block runs the power-up configuration of a reconfigurable logic device that holds two stored images: a write-protected factory image and an upgrade image that may be rewritten in the field. When reset is released it reads a stored boot-preference bit once, enables the chosen image store and issues an active-low program pulse. It then waits for the device's init line before it starts a bounded wait for the configuration-complete line.

If the upgrade image does not complete within the time limit, the block starts a second attempt from the factory image and records that a fallback happened. A corrupted or missing upgrade image causes this case. If the factory image also fails, the block stops in a fault state until the next reset. Status outputs report which image is running and whether a fallback took place. A write-enable path is offered for the upgrade store only, and only while no configuration attempt is in progress.

Top module: `cfg_image_selector`

## Requirements
- R1: While `rst_n` is low, `prog_n` is 1, `en_upgrade` is 1, `en_default` is 0, and `loaded_upgrade`, `loaded_default`, `fell_back`, `cfg_ok` and `fault` are all 0.
- R2: `boot_pref` is sampled once, on the first rising clock edge after reset is released. A value of 1 makes the upgrade image the first attempt and 0 makes the factory image the first attempt. Later changes of `boot_pref` have no effect until the next reset.
- R3: Each attempt begins with `prog_n` low for exactly `PROG_CYCLES` consecutive cycles. Both store enables are 0 while `prog_n` is low.
- R4: After the program pulse, the timeout does not run while `cfg_init` is low. The block waits with `prog_n` high for any length of time and starts no new attempt.
- R5: The attempt window opens on the clock edge that sees `cfg_init` high. `cfg_done` sampled high on any of the following `TIMEOUT_CYCLES` rising edges ends configuration with `cfg_ok` at 1 and the matching `loaded_upgrade` or `loaded_default` flag at 1.
- R6: If the upgrade attempt sees no `cfg_done` within its window, a new program pulse starts on the next edge and the factory image is enabled for it. `fell_back` is then 1. A `cfg_done` that arrives after the window has closed is ignored.
- R7: If the factory-image attempt sees no `cfg_done` within its window, `fault` becomes 1, `prog_n` stays high and no further attempt occurs until reset. Reset clears the fault.
- R8: Whenever `prog_n` is high, exactly one of `en_upgrade` and `en_default` is 1.
- R9: Once `cfg_ok` is 1, it and the `loaded_upgrade`, `loaded_default` and `fell_back` flags keep their values until reset, regardless of `cfg_done`, `cfg_init` or `boot_pref`.
- R10: `def_wr_en` is always 0. `upg_wr_en` equals `wr_req` when `cfg_ok` or `fault` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_pref | input | 1 | Stored preference: 1 = try upgrade image first |
| cfg_init | input | 1 | Device init status, high when ready to accept an image |
| cfg_done | input | 1 | Device configuration-complete line |
| wr_req | input | 1 | Request to write the upgrade store |
| prog_n | output | 1 | Active-low program request pulse |
| en_upgrade | output | 1 | Upgrade image store enable |
| en_default | output | 1 | Factory image store enable |
| upg_wr_en | output | 1 | Write enable for the upgrade store |
| def_wr_en | output | 1 | Write enable for the factory store (held low) |
| loaded_upgrade | output | 1 | Device configured from the upgrade image |
| loaded_default | output | 1 | Device configured from the factory image |
| fell_back | output | 1 | A fallback from upgrade to factory occurred |
| cfg_ok | output | 1 | Configuration complete |
| fault | output | 1 | Both permitted attempts failed, terminal |

## Verification
The hardest situations to reach from the ports are the edges of the attempt window. These are a `cfg_done` that lands on the very last counted edge, and one that lands a single edge later, after the fallback pulse has already begun. The bench raises `cfg_init` on a known falling edge and counts falling edges from that point, so it places `cfg_done` on either side of the limit. It uses a small `TIMEOUT_CYCLES` for this. The terminal fault is reached by starting with the factory-first preference and never raising `cfg_done`.

// File: rtl/cfg_sel_pkg.sv
package cfg_sel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_INIT,
    ST_RUN,
    ST_CONF,
    ST_FAULT
  } sel_state_t;

  typedef enum logic {
    IMG_FACTORY = 1'b0,
    IMG_UPGRADE = 1'b1
  } img_t;

  // True on the final counted cycle of a window of 'limit' cycles.
  function automatic logic window_end(input logic [31:0] count,
                                      input logic [31:0] limit);
    return count == (limit - 32'd1);
  endfunction

  function automatic int cnt_width(input int a, input int b);
    return $clog2((a > b ? a : b) + 1) + 1;
  endfunction

endpackage

// File: rtl/cfg_sel_cycle_cnt.sv
module cfg_sel_cycle_cnt #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // R5: the window counter is sized so it never wraps
  p_cnt_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && !clr && (&cnt)));

endmodule

// File: rtl/cfg_sel_fsm.sv
module cfg_sel_fsm
  import cfg_sel_pkg::*;
#(
  parameter int PROG_CYCLES    = 16,
  parameter int TIMEOUT_CYCLES = 1 << 20,
  parameter int W              = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         boot_pref,
  input  logic         cfg_init,
  input  logic         cfg_done,
  input  logic [W-1:0] cnt,
  output logic         cnt_clr,
  output logic         cnt_inc,
  output logic         expire_evt,
  output sel_state_t   state,
  output img_t         img,
  output logic         fell_back
);

  sel_state_t nxt_state;
  img_t       nxt_img;
  logic       nxt_fb;
  logic       pulse_end;
  logic       run_end;

  assign pulse_end = window_end(32'(cnt), 32'(PROG_CYCLES));
  assign run_end   = window_end(32'(cnt), 32'(TIMEOUT_CYCLES));

  always_comb begin
    nxt_state  = state;
    nxt_img    = img;
    nxt_fb     = fell_back;
    cnt_clr    = 1'b0;
    cnt_inc    = 1'b0;
    expire_evt = 1'b0;
    unique case (state)
      ST_IDLE: begin
        nxt_img   = boot_pref ? IMG_UPGRADE : IMG_FACTORY;
        nxt_state = ST_PROG;
        cnt_clr   = 1'b1;
      end
      ST_PROG: begin
        if (pulse_end) begin
          nxt_state = ST_WAIT_INIT;
          cnt_clr   = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_WAIT_INIT: begin
        cnt_clr = 1'b1;
        if (cfg_init) nxt_state = ST_RUN;
      end
      ST_RUN: begin
        if (cfg_done) begin
          nxt_state = ST_CONF;
        end else if (run_end) begin
          expire_evt = 1'b1;
          cnt_clr    = 1'b1;
          if (img == IMG_UPGRADE) begin
            nxt_img   = IMG_FACTORY;
            nxt_fb    = 1'b1;
            nxt_state = ST_PROG;
          end else begin
            nxt_state = ST_FAULT;
          end
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_CONF, ST_FAULT: nxt_state = state;
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      img       <= IMG_UPGRADE;
      fell_back <= 1'b0;
    end else begin
      state     <= nxt_state;
      img       <= nxt_img;
      fell_back <= nxt_fb;
    end
  end

  // R2: image choice only changes when leaving idle or on a fallback
  p_pref_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !expire_evt) |=> $stable(img));

  // R4: no progress while init is low
  p_init_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_INIT && !cfg_init) |=> state == ST_WAIT_INIT);

  // R6: an expired upgrade attempt restarts from the factory image
  p_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && img == IMG_UPGRADE) |=>
      (state == ST_PROG && img == IMG_FACTORY && fell_back));

  // R7: fault is terminal
  p_fault_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FAULT |=> state == ST_FAULT);

endmodule

// File: rtl/cfg_image_selector.sv
module cfg_image_selector
  import cfg_sel_pkg::*;
#(
  parameter int PROG_CYCLES    = 16,
  parameter int TIMEOUT_CYCLES = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_pref,
  input  logic cfg_init,
  input  logic cfg_done,
  input  logic wr_req,
  output logic prog_n,
  output logic en_upgrade,
  output logic en_default,
  output logic upg_wr_en,
  output logic def_wr_en,
  output logic loaded_upgrade,
  output logic loaded_default,
  output logic fell_back,
  output logic cfg_ok,
  output logic fault
);

  localparam int W = cnt_width(PROG_CYCLES, TIMEOUT_CYCLES);

  logic         cnt_clr;
  logic         cnt_inc;
  logic         expire_evt;
  logic [W-1:0] cnt;
  sel_state_t   state;
  img_t         img;

  cfg_sel_cycle_cnt #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  cfg_sel_fsm #(
    .PROG_CYCLES    (PROG_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .W              (W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_pref  (boot_pref),
    .cfg_init   (cfg_init),
    .cfg_done   (cfg_done),
    .cnt        (cnt),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .expire_evt (expire_evt),
    .state      (state),
    .img        (img),
    .fell_back  (fell_back)
  );

  assign prog_n         = (state != ST_PROG);
  assign en_upgrade     = prog_n && (img == IMG_UPGRADE);
  assign en_default     = prog_n && (img == IMG_FACTORY);
  assign cfg_ok         = (state == ST_CONF);
  assign fault          = (state == ST_FAULT);
  assign loaded_upgrade = cfg_ok && (img == IMG_UPGRADE);
  assign loaded_default = cfg_ok && (img == IMG_FACTORY);
  assign upg_wr_en      = wr_req && (cfg_ok || fault);
  assign def_wr_en      = 1'b0;

  // R3: stores are dark during the program pulse
  p_pulse_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (!en_upgrade && !en_default));

  // R8: one store enabled outside the pulse
  p_one_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_n |-> ($countones({en_upgrade, en_default}) == 1));

  // R9: status frozen once configured
  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |=> (cfg_ok && $stable({loaded_upgrade, loaded_default, fell_back})));

  // R10: upgrade writes only outside an attempt
  p_write_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upg_wr_en |-> (prog_n && (cfg_ok || fault)));

endmodule

// File: tb/tb_cfg_image_selector.sv
module tb_cfg_image_selector;

  localparam int PC = 4;
  localparam int TO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_pref = 1'b1;
  logic cfg_init = 1'b0;
  logic cfg_done = 1'b0;
  logic wr_req = 1'b0;
  logic prog_n, en_upgrade, en_default, upg_wr_en, def_wr_en;
  logic loaded_upgrade, loaded_default, fell_back, cfg_ok, fault;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cfg_image_selector #(.PROG_CYCLES(PC), .TIMEOUT_CYCLES(TO)) dut (
    .clk(clk), .rst_n(rst_n), .boot_pref(boot_pref), .cfg_init(cfg_init),
    .cfg_done(cfg_done), .wr_req(wr_req), .prog_n(prog_n),
    .en_upgrade(en_upgrade), .en_default(en_default), .upg_wr_en(upg_wr_en),
    .def_wr_en(def_wr_en), .loaded_upgrade(loaded_upgrade),
    .loaded_default(loaded_default), .fell_back(fell_back), .cfg_ok(cfg_ok),
    .fault(fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic reset_dut(input logic pref);
    @(negedge clk);
    rst_n = 1'b0; cfg_init = 1'b0; cfg_done = 1'b0; wr_req = 1'b0;
    boot_pref = pref;
    repeat (3) @(negedge clk);
    chk("R1 prog_n in reset", int'(prog_n), 1);
    chk("R1 enables in reset", int'({en_upgrade, en_default}), 2);
    chk("R1 status in reset",
        int'({loaded_upgrade, loaded_default, fell_back, cfg_ok, fault}), 0);
    rst_n = 1'b1;
  endtask

  // Returns the low length of the next program pulse; ends on a negedge with prog_n high.
  task automatic measure_pulse(output int len);
    int guard = 0;
    while (prog_n && guard < 1000) begin @(negedge clk); guard++; end
    len = 0;
    while (!prog_n && len < 1000) begin
      chk("R3 enables dark in pulse", int'({en_upgrade, en_default}), 0);
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_upgrade_ok();
    int len;
    reset_dut(1'b1);
    @(negedge clk);
    boot_pref = 1'b0;  // after sampling edge: must be ignored (R2)
    measure_pulse(len);
    chk("R3 pulse length", len, PC);
    chk("R2 upgrade chosen", int'({en_upgrade, en_default}), 2);
    for (int i = 0; i < TO + 20; i++) begin
      @(negedge clk);
      if (!prog_n || cfg_ok || fault) begin
        chk("R4 waits for init", 0, 1);
        break;
      end
    end
    chk("R4 still waiting", int'({prog_n, cfg_ok, fault}), 3'b100);
    cfg_init = 1'b1;
    repeat (10) @(negedge clk);
    cfg_done = 1'b1;
    @(negedge clk);
    chk("R5 cfg_ok", int'(cfg_ok), 1);
    chk("R5 loaded upgrade", int'({loaded_upgrade, loaded_default, fell_back}), 3'b100);
    cfg_done = 1'b0; cfg_init = 1'b0; boot_pref = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 status held", int'({cfg_ok, loaded_upgrade, loaded_default, fell_back}), 4'b1100);
    wr_req = 1'b1;
    #1;
    chk("R10 upgrade write when configured", int'(upg_wr_en), 1);
    chk("R10 factory write blocked", int'(def_wr_en), 0);
    wr_req = 1'b0;
  endtask

  task automatic t_fallback();
    int len;
    int n;
    reset_dut(1'b1);
    wr_req = 1'b1;
    measure_pulse(len);
    chk("R10 no upgrade write during attempt", int'(upg_wr_en), 0);
    chk("R10 factory write blocked", int'(def_wr_en), 0);
    wr_req = 1'b0;
    cfg_init = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (prog_n && n < 1000);
    chk("R6 fallback after window", n, TO + 1);
    measure_pulse(len);
    chk("R3 second pulse length", len, PC);
    chk("R6 factory enabled", int'({en_upgrade, en_default}), 1);
    chk("R6 fell_back", int'(fell_back), 1);
    repeat (3) @(negedge clk);
    cfg_done = 1'b1;
    @(negedge clk);
    chk("R6 loaded factory after fallback",
        int'({cfg_ok, loaded_upgrade, loaded_default, fell_back}), 4'b1011);
    cfg_done = 1'b0;
  endtask

  task automatic t_fault();
    int len;
    int n;
    reset_dut(1'b0);
    measure_pulse(len);
    chk("R2 factory chosen", int'({en_upgrade, en_default}), 1);
    cfg_init = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!fault && n < 1000);
    chk("R7 fault after window", n, TO + 1);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!prog_n || !fault) begin
        chk("R7 no retry", 0, 1);
        break;
      end
    end
    chk("R8 one enable in fault", int'({en_upgrade, en_default}), 1);
    chk("R7 status in fault", int'({cfg_ok, fell_back}), 0);
    wr_req = 1'b1;
    #1;
    chk("R10 upgrade write in fault", int'(upg_wr_en), 1);
    wr_req = 1'b0;
    reset_dut(1'b1);
    @(negedge clk);
    chk("R7 reset clears fault", int'(fault), 0);
  endtask

  task automatic t_window_edges();
    int len;
    reset_dut(1'b1);
    measure_pulse(len);
    cfg_init = 1'b1;
    repeat (TO) @(negedge clk);
    cfg_done = 1'b1;
    @(negedge clk);
    chk("R5 done on last window edge",
        int'({cfg_ok, loaded_upgrade, fell_back}), 3'b110);
    reset_dut(1'b1);
    measure_pulse(len);
    cfg_init = 1'b1;
    repeat (TO + 1) @(negedge clk);
    cfg_done = 1'b1;
    @(negedge clk);
    chk("R6 late done ignored", int'({prog_n, cfg_ok}), 0);
    chk("R6 factory after late done", int'(fell_back), 1);
    cfg_done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    t_upgrade_ok();
    t_fallback();
    t_fault();
    t_window_edges();
    summary();
    $finish;
  end

endmodule